// File: doc/BRIEF.md
# Fractional Audio Clock Divider

This block derives a slower audio clock from a fast parent clock. Each output period lasts a whole number of parent cycles. The average period is set by a single 32-bit configuration word that combines three terms:

- an integer field that counts double;
- a half-step bit that adds one parent cycle;
- a fraction expressed in 255ths.

The fraction is spread over time by a modulo-255 phase accumulator. Each period adds the fraction numerator to the accumulator. Whenever the sum reaches 255, that period is stretched by one extra parent cycle.

The block drives two outputs:

- a one-cycle enable pulse on the last parent cycle of each output period;
- a square-ish clock that is high for the first half of each period.

Software writes the configuration word over a plain write strobe and can read it back at any time. One bit of the word, active low, runs or stops the divider. A new ratio is picked up only at the next period boundary. Programming a ratio that is too small stops the output and latches a sticky error until reset.

Top module: `aud_frac_div`

## Requirements
- R1: Configuration word fields: bits 7:0 are the fraction F, bits 23:16 the integer N, bit 24 the half-step S and bit 25 the stop bit. While running, each output period lasts 2*N + S parent cycles, plus one more cycle in periods where the accumulator wraps.
- R2: A period starts by adding F to a modulo-255 accumulator. When the sum is 255 or more, 255 is subtracted and that period gets the extra cycle. The accumulator starts at 0, so over 255 periods exactly F of them are stretched; F = 255 stretches every period.
- R3: While bit 25 is 1, clk_en_o and clk_o are held at 0 from the cycle after the write. The accumulator returns to 0, so the next run starts its pattern afresh.
- R4: After reset the configuration word reads 0x0200FF00 (stopped) and all outputs are 0. Writing a word with bit 25 = 0 and N >= 1 starts output periods on the following cycles.
- R5: A write that lands inside a running period does not change that period's length. The new ratio applies from the next period onward.
- R6: If bit 25 is 0 while N = 0 (ratio below 2), err_o rises one cycle later and stays 1 until reset, even after a legal word is written. While err_o is 1, both clock outputs stay 0.
- R7: rd_data_o always equals the last word written, all 32 bits. Bits 15:8, bit 28 and the other unlisted bits have no effect on the output timing.
- R8: clk_en_o is a single-cycle pulse on the last cycle of each period. clk_o is high for the first floor(L/2) cycles of a period of length L, and is low during the pulse.
- R9: The smallest legal ratio, N = 1, S = 0, F = 0, yields a pulse every second parent cycle, and two pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 32 | Configuration word to write |
| rd_data_o | output | 32 | Current configuration word |
| clk_en_o | output | 1 | One-cycle pulse at the end of each output period |
| clk_o | output | 1 | Divided clock, high in the first half of each period |
| err_o | output | 1 | Sticky flag: a ratio below 2 was enabled |

## Verification
Two events can fall in the same parent cycle: a configuration write and the period boundary at which the accumulator and length are reloaded. The bench provokes this by putting the write strobe up in the very cycle after a pulse is seen, so the register update coincides with the period restart. It then judges the outcome by the measured intervals: the old length must still govern the period just begun, and the new one only the following period. Fractional patterns are judged the same way, interval by interval, against a model of the modulo-255 accumulator kept in the bench.

// File: rtl/aud_div_pkg.sv
package aud_div_pkg;
  localparam int unsigned CFG_W     = 32;
  localparam int unsigned FRAC_LSB  = 0;
  localparam int unsigned INT_LSB   = 16;
  localparam int unsigned HALF_BIT  = 24;
  localparam int unsigned STOP_BIT  = 25;
  localparam logic [CFG_W-1:0] CFG_RST = 32'h0200_FF00;
endpackage

// File: rtl/aud_cfg_reg.sv
module aud_cfg_reg #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] cfg_o
);
  logic [DW-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= RST_VAL;
    else if (wr_en_i) cfg_q <= wr_data_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/aud_frac_acc.sv
module aud_frac_acc #(
  parameter int unsigned FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [FW-1:0] frac_i,
  output logic          extra_o
);
  localparam logic [FW:0] MOD = {1'b0, {FW{1'b1}}};

  logic [FW-1:0] acc_q;
  logic [FW:0]   sum;
  logic [FW:0]   wrapped;
  logic          wrap;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, frac_i};
    wrap    = (sum >= MOD);
    wrapped = wrap ? (sum - MOD) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (step_i)  acc_q <= wrapped[FW-1:0];
  end

  assign extra_o = wrap;
endmodule

// File: rtl/aud_period_ctr.sv
module aud_period_ctr #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          act_o,
  output logic          last_o,
  output logic          high_o
);
  logic          act_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
      len_q <= len_i;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o  = act_q;
  assign last_o = act_q && (cnt_q == len_q - 1'b1);
  assign high_o = act_q && (cnt_q < (len_q >> 1));
endmodule

// File: rtl/aud_frac_div.sv
module aud_frac_div
  import aud_div_pkg::*;
#(
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned INT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [CFG_W-1:0] rd_data_o,
  output logic             clk_en_o,
  output logic             clk_o,
  output logic             err_o
);
  localparam int unsigned CW = INT_W + 2;

  logic [CFG_W-1:0] cfg;
  logic [FRAC_W-1:0] frac;
  logic [INT_W-1:0]  nint;
  logic              half, stop;
  logic              err_q, bad, run_ok;
  logic              act, last, high, start, extra;
  logic [CW-1:0]     len;

  aud_cfg_reg #(.DW(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .cfg_o(cfg)
  );

  assign frac = cfg[FRAC_LSB +: FRAC_W];
  assign nint = cfg[INT_LSB +: INT_W];
  assign half = cfg[HALF_BIT];
  assign stop = cfg[STOP_BIT];

  assign bad    = !stop && (nint == '0);
  assign run_ok = !stop && (nint != '0) && !err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end

  // new period when idle-to-run or on the last cycle of the current one
  assign start = run_ok && (!act || last);

  aud_frac_acc #(.FW(FRAC_W)) u_acc (
    .clk_i, .rst_ni,
    .clr_i  (!run_ok),
    .step_i (start),
    .frac_i (frac),
    .extra_o(extra)
  );

  assign len = {1'b0, nint, 1'b0} + CW'(half) + CW'(extra);

  aud_period_ctr #(.CW(CW)) u_ctr (
    .clk_i, .rst_ni,
    .clr_i (!run_ok),
    .load_i(start),
    .len_i (len),
    .act_o (act),
    .last_o(last),
    .high_o(high)
  );

  assign rd_data_o = cfg;
  assign clk_en_o  = run_ok && last;
  assign clk_o     = run_ok && high;
  assign err_o     = err_q;
endmodule

// File: rtl/aud_frac_div_chk.sv
module aud_frac_div_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] rd_data_o,
  input logic        clk_en_o,
  input logic        clk_o,
  input logic        err_o
);
  a_r3_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[25] |-> (!clk_en_o && !clk_o));

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r6_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!clk_en_o && !clk_o));

  a_r6_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(!rd_data_o[25] && (rd_data_o[23:16] == 8'd0)));

  a_r9_no_adjacent_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |=> !clk_en_o);

  a_r8_pulse_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> !clk_o);
endmodule

bind aud_frac_div aud_frac_div_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_data_o(rd_data_o),
  .clk_en_o(clk_en_o), .clk_o(clk_o), .err_o(err_o)
);

// File: tb/aud_frac_div_test.sv
module aud_frac_div_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        clk_en_o, clk_o, err_o;

  int checks = 0;
  int fails  = 0;

  always #5ns clk_i = ~clk_i;

  aud_frac_div uut (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
    .clk_en_o, .clk_o, .err_o
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] sum;  // cycles over periods 2..9
    logic [31:0] hi;   // clk_o high cycles over periods 2..9
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h0002_FF00, 32'd32, 32'd16},
    '{32'h1103_FF00, 32'd56, 32'd24},
    '{32'h0001_FF80, 32'd20, 32'd8},
    '{32'h0102_FFFF, 32'd48, 32'd24},
    '{32'h0101_FF55, 32'd27, 32'd11},
    '{32'h0001_FF00, 32'd16, 32'd8}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk_i); while (!clk_en_o);
  endtask

  task automatic run_vec(input vec_t v);
    int acc_m, len_m, n, hi, tot, thi;
    bit seq_ok;
    logic [31:0] bad_len, bad_exp;
    wr(v.cfg | 32'h0200_0000);
    repeat (2) @(negedge clk_i);
    wr(v.cfg);
    acc_m = 0; tot = 0; thi = 0; seq_ok = 1'b1; bad_len = '0; bad_exp = '0;
    acc_m += v.cfg[7:0];
    if (acc_m >= 255) acc_m -= 255;
    wait_pulse();
    for (int p = 2; p <= 9; p++) begin
      acc_m += v.cfg[7:0];
      len_m = 2 * v.cfg[23:16] + v.cfg[24];
      if (acc_m >= 255) begin acc_m -= 255; len_m++; end
      n = 0; hi = 0;
      do begin @(negedge clk_i); n++; hi += clk_o; end while (!clk_en_o);
      if (n != len_m && seq_ok) begin seq_ok = 1'b0; bad_len = n; bad_exp = len_m; end
      tot += n; thi += hi;
    end
    chk(seq_ok, "R2 per-period length", bad_len, bad_exp);
    chk(tot == v.sum, "R1 total period cycles", tot, v.sum);
    chk(thi == v.hi, "R8 clk_o high cycles", thi, v.hi);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit quiet;
    @(negedge clk_i);
    // R4 reset state
    chk(rd_data_o == 32'h0200_FF00, "R4 reset word", rd_data_o, 32'h0200_FF00);
    chk(!clk_en_o && !clk_o && !err_o, "R4 reset outputs", {clk_en_o, clk_o, err_o}, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!clk_en_o && !clk_o, "R4 idle while stopped", {clk_en_o, clk_o}, 0);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R7 readback of last word (bits 28, 15:8 included)
    wr(32'h1103_FF00);
    chk(rd_data_o == 32'h1103_FF00, "R7 readback", rd_data_o, 32'h1103_FF00);

    // R3 stop: outputs quiet, restart from accumulator 0 (R2)
    wr(32'h0001_FF80);
    wait_pulse();
    wait_pulse();
    wr(32'h0201_FF80);
    quiet = 1'b1;
    repeat (20) begin @(negedge clk_i); if (clk_en_o || clk_o) quiet = 1'b0; end
    chk(quiet, "R3 stopped outputs low", !quiet, 0);
    wr(32'h0001_FF80);
    wait_pulse();
    n = 0;
    do begin @(negedge clk_i); n++; end while (!clk_en_o);
    chk(n == 3, "R3 accumulator restarts at 0", n, 3);

    // R5 write at the period boundary: current period keeps old length
    wr(32'h0201_FF00);
    repeat (2) @(negedge clk_i);
    wr(32'h0002_FF00);
    wait_pulse();
    wait_pulse();
    wr_en_i = 1'b1;
    wr_data_i = 32'h0005_FF00;
    n = 0;
    do begin
      @(negedge clk_i); n++;
      wr_en_i = 1'b0;
    end while (!clk_en_o);
    chk(n == 4, "R5 period in flight unchanged", n, 4);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!clk_en_o);
    chk(n == 10, "R5 new ratio next period", n, 10);

    // R6 ratio below 2
    wr(32'h0100_FF00);
    @(negedge clk_i);
    chk(err_o == 1'b1, "R6 error raised", err_o, 1);
    quiet = 1'b1;
    repeat (10) begin @(negedge clk_i); if (clk_en_o || clk_o) quiet = 1'b0; end
    chk(quiet, "R6 outputs low on error", !quiet, 0);
    wr(32'h0002_FF00);
    quiet = 1'b1;
    repeat (20) begin @(negedge clk_i); if (clk_en_o || clk_o || !err_o) quiet = 1'b0; end
    chk(quiet, "R6 error sticky, outputs low", !quiet, 0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!err_o, "R6 reset clears error", err_o, 0);
    rst_ni = 1'b1;

    // R9 minimum ratio: pulse every second cycle
    wr(32'h0001_FF00);
    wait_pulse();
    n = 0;
    do begin @(negedge clk_i); n++; end while (!clk_en_o);
    chk(n == 2, "R9 minimum ratio interval", n, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule